// File: doc/BRIEF.md
# Normal Colour Lighting Datapath

This block lights one vertex normal in fixed point, or three normals back to back in triple mode. Each normal goes through three passes.

1. The light matrix turns the normal into a light intensity vector.
2. The light-colour matrix turns that intensity into a lit colour, and a background colour is added.
3. Each lit channel is scaled by the vertex's base colour.

The result of the third pass is clamped to 8 bits per channel and pushed into a three-entry colour FIFO, together with the code byte of the base colour.

The datapath has a single row unit: a three-term multiply-accumulate with a bias input. A small sequencer feeds it one matrix row or one colour channel per clock, so each normal takes ten cycles. Nine of them commit accumulator (MAC) and intermediate (IR) values, and the tenth pushes the colour. A sticky flag word records every clamp and overflow event. Its top bit summarises the error events once the whole run is over, and `done` then pulses for one cycle.

Top module: `nclt_lighting`

## Requirements
- R1: After reset, `mac_o`, `ir_o`, `rgb0`, `rgb1`, `rgb2`, `flag` and `done` are all zero.
- R2: Pass one writes channel r of `mac_o` and `ir_o` from S = sum over j of L[r][j]·V[j]. The MAC is the low 32 bits of S arithmetically shifted right by 12 when `sf`=1, or unshifted when `sf`=0.
- R3: Pass two computes S = BK[r]·4096 + sum over j of C[r][j]·IR[j], with the same shift and clamp as pass one. It uses the IR vector as it stood at the end of pass one.
- R4: Pass three sets MACi = ((zero-extended base channel i × IRi)·16) shifted as in R2. Every IR is clamped from its 32-bit MAC to the range [−32768, 32767] when `lm`=0, or [0, 32767] when `lm`=1.
- R5: Each colour byte is MACi arithmetically shifted right by 4 and clamped to 0..255. A push moves `rgb1` to `rgb0` and `rgb2` to `rgb1`, then writes `rgb2` = {code, B, G, R}, with R in bits 7:0 and the code in bits 31:24. Base colour input layout: R[7:0], G[15:8], B[23:16], code[31:24].
- R6: When `triple`=1 the normals are processed in the order `normal0`, `normal1`, `normal2`, and three colours are pushed. When `triple`=0 only `normal0` is processed and one colour is pushed.
- R7: `flag` is cleared when a start is accepted, and its event bits are sticky for the rest of the run.
  - Bits 2:0: the pre-shift sum of channel 1..3 fell outside the signed 44-bit range.
  - Bits 5:3: IR1..3 was clamped.
  - Bits 8:6: colour R, G or B was clamped.
- R8: `flag[31]` is written only with the final push of a run, as the OR of bits 5:0.
- R9: `done` is a one-cycle pulse. It rises at the 10th (single) or 30th (triple) rising edge after the edge that samples `start`.
- R10: `start` is ignored while a run is in progress. `triple`, `sf` and `lm` are captured when a start is accepted. While idle, the MAC, IR and FIFO outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| triple | input | 1 | 1 = process three normals, 0 = one |
| sf | input | 1 | 1 = shift sums right by 12 |
| lm | input | 1 | 1 = IR lower clamp is 0 |
| light_mtx | input | 144 | Light matrix, element (r,c) at bits 16·(3r+c) +: 16, signed |
| color_mtx | input | 144 | Light-colour matrix, same layout |
| bk_color | input | 96 | Background colour, channel i at bits 32·i +: 32, signed |
| base_rgbc | input | 32 | Base colour R[7:0], G[15:8], B[23:16], code[31:24] |
| normal0 | input | 48 | Normal 0, x[15:0], y[31:16], z[47:32], signed |
| normal1 | input | 48 | Normal 1, same layout |
| normal2 | input | 48 | Normal 2, same layout |
| mac_o | output | 96 | MAC channel i at bits 32·i +: 32 |
| ir_o | output | 48 | IR channel i at bits 16·i +: 16 |
| rgb0 | output | 32 | Oldest colour FIFO entry |
| rgb1 | output | 32 | Middle colour FIFO entry |
| rgb2 | output | 32 | Newest colour FIFO entry |
| flag | output | 32 | Sticky event flags and summary bit |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that `start` is a pulse which the sequencer filters while busy. They also assume that the matrix, background, base colour and normal inputs stay stable for the whole run, because the datapath reads them again in every pass.

The bench changes those inputs only between runs. The one exception is a deliberate `start` pulse in mid-run, sent with flipped mode bits, which must have no effect. Random stimulus covers the full signed ranges of the matrices and normals, both shift settings and both clamp modes. Directed cases force IR clamping, colour clamping and the 44-bit accumulator overflow.

// File: rtl/nclt_pkg.sv
// Package: shared widths, types and flag layout for the normal colour
// lighting datapath. Assumes 16-bit signed vectors and 32-bit MACs.
package nclt_pkg;
    parameter int VEC_W   = 16;           // normal / matrix / IR width
    parameter int MAC_W   = 32;           // accumulator register width
    parameter int ACC_W   = 44;           // overflow-checked sum width
    parameter int SUM_W   = 48;           // internal sum width
    parameter int FRAC_SH = 12;           // shift applied when sf=1
    parameter int COL_W   = 8;            // colour channel width
    parameter int COL_SH  = 4;            // MAC to colour shift
    parameter int BASE_SH = 4;            // base colour pre-scale
    parameter int NCH     = 3;            // channels per vector
    parameter int NSTEP   = 3 * NCH + 1;  // cycles per normal

    localparam int COEF_W = VEC_W + 1;
    localparam int ENT_W  = 4 * COL_W;
    localparam int STEP_W = $clog2(NSTEP);

    typedef logic signed [VEC_W-1:0]  vec_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [MAC_W-1:0]  mac_t;

    localparam int FL_OVF = 0;   // accumulator overflow, channels 1..3
    localparam int FL_IR  = 3;   // IR clamp, channels 1..3
    localparam int FL_COL = 6;   // colour clamp R, G, B
    localparam int FL_SUM = 31;  // error summary
endpackage

// File: rtl/nclt_row_unit.sv
// Row unit: combinational three-term multiply-accumulate with bias,
// overflow detect, optional fractional shift and IR clamp.
// Assumes a coefficients fit COEF_W signed and x operands VEC_W signed.
module nclt_row_unit
    import nclt_pkg::*;
(
    input  sum_t  bias,
    input  coef_t a [NCH],
    input  vec_t  x [NCH],
    input  logic  sf,
    input  logic  lm,
    output mac_t  mac,
    output vec_t  ir,
    output logic  ovf,
    output logic  sat
);
    localparam sum_t ACC_HI = sum_t'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam sum_t ACC_LO = -ACC_HI - sum_t'(1);
    localparam mac_t IR_HI  = mac_t'((1 <<< (VEC_W - 1)) - 1);
    localparam mac_t IR_LO  = -IR_HI - mac_t'(1);

    sum_t acc;

    // Purpose: sum, overflow check, shift and IR clamp of one row.
    always_comb begin
        acc = bias;
        for (int j = 0; j < NCH; j++)
            acc = acc + sum_t'(a[j]) * sum_t'(x[j]);
        ovf = (acc > ACC_HI) || (acc < ACC_LO);
        mac = mac_t'(sf ? (acc >>> FRAC_SH) : acc);
        sat = 1'b0;
        ir  = mac[VEC_W-1:0];
        if (mac > IR_HI) begin
            ir  = IR_HI[VEC_W-1:0];
            sat = 1'b1;
        end else if (mac < (lm ? mac_t'(0) : IR_LO)) begin
            ir  = lm ? vec_t'(0) : IR_LO[VEC_W-1:0];
            sat = 1'b1;
        end
    end
endmodule

// File: rtl/nclt_color_fifo.sv
// Colour FIFO: converts the three MACs to clamped colour bytes and, on
// push, shifts the three-entry FIFO and writes the newest slot.
// Assumes push only when all three MACs of the colour pass are final.
module nclt_color_fifo
    import nclt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  mac_t             mac [NCH],
    input  logic [COL_W-1:0] code,
    output logic [ENT_W-1:0] rgb0,
    output logic [ENT_W-1:0] rgb1,
    output logic [ENT_W-1:0] rgb2,
    output logic [NCH-1:0]   csat
);
    localparam mac_t COL_MAX = mac_t'((1 << COL_W) - 1);

    mac_t             sh   [NCH];
    logic [COL_W-1:0] chan [NCH];

    // Purpose: shift each MAC down and clamp it to a colour byte.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            sh[i]   = mac[i] >>> COL_SH;
            csat[i] = 1'b0;
            chan[i] = sh[i][COL_W-1:0];
            if (sh[i] > COL_MAX) begin
                chan[i] = COL_MAX[COL_W-1:0];
                csat[i] = 1'b1;
            end else if (sh[i] < mac_t'(0)) begin
                chan[i] = '0;
                csat[i] = 1'b1;
            end
        end
    end

    // Purpose: FIFO shift and newest-slot write on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb0 <= '0;
            rgb1 <= '0;
            rgb2 <= '0;
        end else if (push) begin
            rgb0 <= rgb1;
            rgb1 <= rgb2;
            rgb2 <= {code, chan[2], chan[1], chan[0]};
        end
    end
endmodule

// File: rtl/nclt_ctrl.sv
// Sequencer: accepts start while idle, steps through NSTEP cycles per
// normal for one or three normals, and marks the push cycles.
// Assumes start is a pulse; starts during a run are dropped.
module nclt_ctrl
    import nclt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              triple,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic [1:0]        vidx,
    output logic              launch,
    output logic              push,
    output logic              last_push
);
    logic triple_q;

    // Purpose: decode accept, push and final push.
    always_comb begin
        launch    = start && !busy;
        push      = busy && (step == STEP_W'(NSTEP - 1));
        last_push = push && (vidx == (triple_q ? 2'd2 : 2'd0));
    end

    // Purpose: step and normal counters for a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            step     <= '0;
            vidx     <= '0;
            triple_q <= 1'b0;
        end else if (launch) begin
            busy     <= 1'b1;
            step     <= '0;
            vidx     <= '0;
            triple_q <= triple;
        end else if (busy) begin
            if (push) begin
                step <= '0;
                if (last_push) busy <= 1'b0;
                else           vidx <= vidx + 2'd1;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/nclt_lighting.sv
// Top: normal colour lighting datapath. Per normal it runs three light
// matrix rows, three colour matrix rows and three base colour channels
// through one row unit, then pushes a colour. Assumes the matrix, colour
// and normal inputs are stable for the whole run.
module nclt_lighting
    import nclt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   triple,
    input  logic                   sf,
    input  logic                   lm,
    input  logic [9*VEC_W-1:0]     light_mtx,
    input  logic [9*VEC_W-1:0]     color_mtx,
    input  logic [NCH*MAC_W-1:0]   bk_color,
    input  logic [ENT_W-1:0]       base_rgbc,
    input  logic [NCH*VEC_W-1:0]   normal0,
    input  logic [NCH*VEC_W-1:0]   normal1,
    input  logic [NCH*VEC_W-1:0]   normal2,
    output logic [NCH*MAC_W-1:0]   mac_o,
    output logic [NCH*VEC_W-1:0]   ir_o,
    output logic [ENT_W-1:0]       rgb0,
    output logic [ENT_W-1:0]       rgb1,
    output logic [ENT_W-1:0]       rgb2,
    output logic [31:0]            flag,
    output logic                   done
);
    vec_t             lt   [NCH][NCH];
    vec_t             cl   [NCH][NCH];
    vec_t             nv   [NCH][NCH];
    mac_t             bk   [NCH];
    logic [COL_W-1:0] base [NCH];

    logic              busy, launch, push, last_push;
    logic [STEP_W-1:0] step;
    logic [1:0]        vidx, row, stg;
    logic              sf_q, lm_q, done_q;
    logic [31:0]       flag_q;
    mac_t              mac_q [NCH];
    vec_t              ir_q  [NCH];
    vec_t              opv   [NCH];

    sum_t       bias;
    coef_t      a_s [NCH];
    vec_t       x_s [NCH];
    mac_t       mac_row;
    vec_t       ir_row;
    logic       ovf, irsat;
    logic [NCH-1:0] csat;

    // Unpack the flat input buses into element arrays.
    for (genvar r = 0; r < NCH; r++) begin : g_row
        for (genvar c = 0; c < NCH; c++) begin : g_col
            assign lt[r][c] = light_mtx[VEC_W*(NCH*r+c) +: VEC_W];
            assign cl[r][c] = color_mtx[VEC_W*(NCH*r+c) +: VEC_W];
        end
        assign nv[0][r] = normal0[VEC_W*r +: VEC_W];
        assign nv[1][r] = normal1[VEC_W*r +: VEC_W];
        assign nv[2][r] = normal2[VEC_W*r +: VEC_W];
        assign bk[r]    = bk_color[MAC_W*r +: MAC_W];
        assign base[r]  = base_rgbc[COL_W*r +: COL_W];
        assign mac_o[MAC_W*r +: MAC_W] = mac_q[r];
        assign ir_o[VEC_W*r +: VEC_W]  = ir_q[r];
    end

    nclt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .triple(triple),
        .busy(busy), .step(step), .vidx(vidx), .launch(launch),
        .push(push), .last_push(last_push)
    );

    // Purpose: map the step count to pass and row.
    always_comb begin
        stg = 2'd3;
        row = 2'd0;
        if (step < STEP_W'(NCH)) begin
            stg = 2'd0; row = 2'(step);
        end else if (step < STEP_W'(2*NCH)) begin
            stg = 2'd1; row = 2'(step - STEP_W'(NCH));
        end else if (step < STEP_W'(3*NCH)) begin
            stg = 2'd2; row = 2'(step - STEP_W'(2*NCH));
        end
    end

    // Purpose: select coefficients, operands and bias for the row unit.
    always_comb begin
        bias = '0;
        for (int j = 0; j < NCH; j++) begin
            a_s[j] = '0;
            x_s[j] = '0;
        end
        case (stg)
            2'd0: for (int j = 0; j < NCH; j++) begin
                a_s[j] = coef_t'(lt[row][j]);
                x_s[j] = nv[vidx][j];
            end
            2'd1: begin
                bias = sum_t'(bk[row]) <<< FRAC_SH;
                for (int j = 0; j < NCH; j++) begin
                    a_s[j] = coef_t'(cl[row][j]);
                    x_s[j] = opv[j];
                end
            end
            2'd2: begin
                a_s[0] = coef_t'(base[row]) <<< BASE_SH;
                x_s[0] = ir_q[row];
            end
            default: ;
        endcase
    end

    nclt_row_unit u_row (
        .bias(bias), .a(a_s), .x(x_s), .sf(sf_q), .lm(lm_q),
        .mac(mac_row), .ir(ir_row), .ovf(ovf), .sat(irsat)
    );

    nclt_color_fifo u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .mac(mac_q),
        .code(base_rgbc[ENT_W-1 -: COL_W]),
        .rgb0(rgb0), .rgb1(rgb1), .rgb2(rgb2), .csat(csat)
    );

    // Purpose: commit MAC/IR per row, keep flags and operand snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q   <= 1'b0;
            lm_q   <= 1'b0;
            flag_q <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                mac_q[i] <= '0;
                ir_q[i]  <= '0;
                opv[i]   <= '0;
            end
        end else begin
            done_q <= last_push;
            if (launch) begin
                sf_q   <= sf;
                lm_q   <= lm;
                flag_q <= '0;
            end else if (busy && !push) begin
                mac_q[row] <= mac_row;
                ir_q[row]  <= ir_row;
                flag_q[FL_OVF + 32'(row)] <= flag_q[FL_OVF + 32'(row)] | ovf;
                flag_q[FL_IR + 32'(row)]  <= flag_q[FL_IR + 32'(row)] | irsat;
                if (step == STEP_W'(NCH - 1)) begin
                    opv[0] <= ir_q[0];
                    opv[1] <= ir_q[1];
                    opv[2] <= ir_row;
                end
            end else if (push) begin
                flag_q[FL_COL +: NCH] <= flag_q[FL_COL +: NCH] | csat;
                if (last_push)
                    flag_q[FL_SUM] <= |flag_q[FL_IR + NCH - 1 : FL_OVF];
            end
        end
    end

    assign flag = flag_q;
    assign done = done_q;
endmodule

// File: rtl/nclt_lighting_chk.sv
// Checker: temporal properties of the lighting datapath, bound to the top.
// Assumes start is only honoured while idle (busy low).
module nclt_lighting_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] flag,
    input logic [95:0] mac_o,
    input logic [31:0] rgb0,
    input logic [31:0] rgb1,
    input logic [31:0] rgb2
);
    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the run is over when done is seen
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: the summary bit only rises with the end-of-run pulse
    p_summary_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[31]) |-> done);

    // R7: an accepted start leaves the flag word cleared
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (flag == 32'd0));

    // R10: no FIFO movement while idle
    p_fifo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({rgb0, rgb1, rgb2}));

    // R10: MACs hold while idle and not starting
    p_mac_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(mac_o));
endmodule

bind nclt_lighting nclt_lighting_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .flag(flag), .mac_o(mac_o), .rgb0(rgb0), .rgb1(rgb1), .rgb2(rgb2)
);

// File: tb/nclt_lighting_test.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random runs, each checked against a
// model of the requirements.
module nclt_lighting_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, triple = 1'b0, sf = 1'b0, lm = 1'b0;
    logic [143:0] light_mtx, color_mtx;
    logic [95:0]  bk_color;
    logic [31:0]  base_rgbc;
    logic [47:0]  normal0, normal1, normal2;
    logic [95:0]  mac_o;
    logic [47:0]  ir_o;
    logic [31:0]  rgb0, rgb1, rgb2, flag;
    logic         done;

    int total = 0;
    int bad = 0;

    int lt [3][3];
    int cl [3][3];
    int nrm [3][3];
    int bkv [3];
    int base [3];
    int code;

    int m_mac [3];
    int m_ir [3];
    logic [31:0] m_fifo [3];
    logic [31:0] m_flag;

    always #2 clk = ~clk;

    nclt_lighting uut (
        .clk(clk), .rst_n(rst_n), .start(start), .triple(triple),
        .sf(sf), .lm(lm), .light_mtx(light_mtx), .color_mtx(color_mtx),
        .bk_color(bk_color), .base_rgbc(base_rgbc), .normal0(normal0),
        .normal1(normal1), .normal2(normal2), .mac_o(mac_o), .ir_o(ir_o),
        .rgb0(rgb0), .rgb1(rgb1), .rgb2(rgb2), .flag(flag), .done(done)
    );

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic drive_cfg();
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                light_mtx[16*(3*r+c) +: 16] = lt[r][c][15:0];
                color_mtx[16*(3*r+c) +: 16] = cl[r][c][15:0];
            end
            normal0[16*r +: 16] = nrm[0][r][15:0];
            normal1[16*r +: 16] = nrm[1][r][15:0];
            normal2[16*r +: 16] = nrm[2][r][15:0];
            bk_color[32*r +: 32] = bkv[r];
            base_rgbc[8*r +: 8] = base[r][7:0];
        end
        base_rgbc[31:24] = code[7:0];
    endtask

    task automatic mrow(input longint bias, input longint a [3], input longint x [3],
                        input bit sfb, input bit lmb, output int mac, output int ir,
                        output bit ovf, output bit sat);
        longint s;
        longint s2;
        int lo;
        s = bias;
        for (int j = 0; j < 3; j++) s = s + a[j] * x[j];
        ovf = (s > 64'sd8796093022207) || (s < -64'sd8796093022208);
        s2 = sfb ? (s >>> 12) : s;
        mac = s2[31:0];
        lo = lmb ? 0 : -32768;
        sat = 1'b0;
        ir = mac;
        if (mac > 32767) begin ir = 32767; sat = 1'b1; end
        else if (mac < lo) begin ir = lo; sat = 1'b1; end
    endtask

    task automatic model_run(input int n, input bit sfb, input bit lmb);
        longint a [3];
        longint x [3];
        int ops [3];
        int mac, ir, col;
        bit ovf, sat;
        logic [31:0] ent;
        m_flag = '0;
        for (int v = 0; v < n; v++) begin
            for (int r = 0; r < 3; r++) begin
                for (int j = 0; j < 3; j++) begin a[j] = lt[r][j]; x[j] = nrm[v][j]; end
                mrow(0, a, x, sfb, lmb, mac, ir, ovf, sat);
                m_mac[r] = mac; m_ir[r] = ir;
                m_flag[r] |= ovf; m_flag[3+r] |= sat;
            end
            ops = m_ir;
            for (int r = 0; r < 3; r++) begin
                for (int j = 0; j < 3; j++) begin a[j] = cl[r][j]; x[j] = ops[j]; end
                mrow(longint'(bkv[r]) * 4096, a, x, sfb, lmb, mac, ir, ovf, sat);
                m_mac[r] = mac; m_ir[r] = ir;
                m_flag[r] |= ovf; m_flag[3+r] |= sat;
            end
            for (int r = 0; r < 3; r++) begin
                a[0] = base[r] * 16; a[1] = 0; a[2] = 0;
                x[0] = m_ir[r];      x[1] = 0; x[2] = 0;
                mrow(0, a, x, sfb, lmb, mac, ir, ovf, sat);
                m_mac[r] = mac; m_ir[r] = ir;
                m_flag[r] |= ovf; m_flag[3+r] |= sat;
            end
            ent = {code[7:0], 24'd0};
            for (int c = 0; c < 3; c++) begin
                col = m_mac[c] >>> 4;
                if (col > 255) begin col = 255; m_flag[6+c] = 1'b1; end
                else if (col < 0) begin col = 0; m_flag[6+c] = 1'b1; end
                ent[8*c +: 8] = col[7:0];
            end
            m_fifo[0] = m_fifo[1];
            m_fifo[1] = m_fifo[2];
            m_fifo[2] = ent;
        end
        m_flag[31] = |m_flag[5:0];
    endtask

    // One run on the DUT. inject>0 pulses start with flipped modes then.
    task automatic run(input string tag, input bit tr, input bit sfb, input bit lmb,
                       input int inject);
        int cnt;
        int n;
        n = tr ? 3 : 1;
        drive_cfg();
        model_run(n, sfb, lmb);
        triple = tr; sf = sfb; lm = lmb; start = 1'b1;
        cnt = 0;
        while (cnt < 100) begin
            @(negedge clk);
            cnt++;
            start = (cnt == inject);
            if (cnt == inject) begin triple = ~tr; sf = ~sfb; lm = ~lmb; end
            if (done) break;
        end
        start = 1'b0;
        chk({tag, " R9 latency"}, 128'(cnt), 128'(10 * n + 1));
        for (int c = 0; c < 3; c++) begin
            chk({tag, " R2 R3 R4 mac"}, 128'(mac_o[32*c +: 32]), 128'(m_mac[c][31:0]));
            chk({tag, " R4 ir"}, 128'(ir_o[16*c +: 16]), 128'(m_ir[c][15:0]));
        end
        chk({tag, " R5 R6 rgb0"}, 128'(rgb0), 128'(m_fifo[0]));
        chk({tag, " R5 R6 rgb1"}, 128'(rgb1), 128'(m_fifo[1]));
        chk({tag, " R5 rgb2"}, 128'(rgb2), 128'(m_fifo[2]));
        chk({tag, " R7 R8 flag"}, 128'(flag), 128'(m_flag));
        @(negedge clk);
        chk({tag, " R9 done pulse"}, 128'(done), 128'(0));
    endtask

    task automatic zero_cfg();
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                lt[r][c] = 0; cl[r][c] = 0; nrm[r][c] = 0;
            end
            bkv[r] = 0; base[r] = 0;
        end
        code = 0;
    endtask

    function automatic int srnd16();
        logic [15:0] v;
        v = 16'($urandom);
        return int'($signed(v));
    endfunction

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < 3; i++) m_fifo[i] = '0;
        zero_cfg();
        drive_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 mac", 128'(mac_o), 128'(0));
        chk("R1 ir", 128'(ir_o), 128'(0));
        chk("R1 fifo", 128'({rgb0, rgb1, rgb2}), 128'(0));
        chk("R1 flag", 128'(flag), 128'(0));
        chk("R1 done", 128'(done), 128'(0));

        // R2 R4 R5: unit matrices, sf=1, mixed-sign normal
        for (int i = 0; i < 3; i++) begin lt[i][i] = 4096; cl[i][i] = 4096; end
        nrm[0][0] = 1000; nrm[0][1] = -2000; nrm[0][2] = 3000;
        base[0] = 8'h80; base[1] = 8'h40; base[2] = 8'h20; code = 8'h5A;
        run("unit sf1 lm0", 1'b0, 1'b1, 1'b0, 0);
        chk("R5 red byte 500>>4", 128'(rgb2[7:0]), 128'(31));
        chk("R5 green clamp to 0", 128'(rgb2[15:8]), 128'(0));
        chk("R5 code byte", 128'(rgb2[31:24]), 128'(8'h5A));

        // R4: lm=1 clamps the negative IR to 0
        run("unit sf1 lm1", 1'b0, 1'b1, 1'b1, 0);
        chk("R4 lm clamp flag", 128'(flag[4]), 128'(1));
        chk("R8 summary set", 128'(flag[31]), 128'(1));

        // R2 R4: sf=0, IR saturates high
        run("unit sf0", 1'b0, 1'b0, 1'b0, 0);

        // R7: 44-bit accumulator overflow on channel 1
        bkv[0] = 32'h7FFFFFFF; cl[0][0] = 32767; nrm[0][0] = 30000;
        run("overflow", 1'b0, 1'b1, 1'b0, 0);
        chk("R7 overflow bit0", 128'(flag[0]), 128'(1));
        chk("R8 summary overflow", 128'(flag[31]), 128'(1));

        // R6: triple mode with distinct normals
        zero_cfg();
        for (int i = 0; i < 3; i++) begin lt[i][i] = 4096; cl[i][i] = 4096; end
        for (int v = 0; v < 3; v++)
            for (int c = 0; c < 3; c++) nrm[v][c] = 800 * (v + 1) + 200 * c;
        base[0] = 8'hFF; base[1] = 8'h10; base[2] = 8'h08; code = 8'hC3;
        run("triple order", 1'b1, 1'b1, 1'b0, 0);

        // R10: start during a run is ignored; nothing moves afterwards
        nrm[0][0] = 4000; nrm[0][1] = 100; nrm[0][2] = -100;
        run("start ignored", 1'b0, 1'b1, 1'b0, 4);
        begin
            int seen;
            logic [95:0] f0;
            seen = 0;
            f0 = {rgb0, rgb1, rgb2};
            repeat (15) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R10 no extra run done", 128'(seen), 128'(0));
            chk("R10 fifo held", 128'({rgb0, rgb1, rgb2}), 128'(f0));
        end

        // Random runs across modes and full ranges
        for (int k = 0; k < 40; k++) begin
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 3; c++) begin
                    lt[r][c] = srnd16();
                    cl[r][c] = srnd16();
                    nrm[r][c] = srnd16();
                end
                bkv[r] = ($urandom_range(0, 3) == 0) ? int'($urandom)
                                                     : int'($urandom_range(0, 2097151)) - 1048576;
                base[r] = $urandom_range(0, 255);
            end
            code = $urandom_range(0, 255);
            run($sformatf("random %0d", k), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule